// File: doc/BRIEF.md
# Dual Address Cycle Sequencer

This block runs the address phases of a memory transaction for a bus master whose targets may decode only 32 address bits. A request carries a 64-bit address and a 4-bit command. When the upper half of the address is zero, the block puts out one ordinary address phase. When the upper half is non-zero and the command is a memory command, it puts out a dual address cycle. The first phase carries the dual-address command code and the low address word. The second phase carries the high address word and the real command. Once the address phases are finished, it hands the command and address on to the data-phase logic.

A parameter selects between a 32-bit master and a 64-bit master. With a 64-bit master, the first phase of a dual cycle also drives the high address word and the real command on the upper lanes. A 64-capable target can then decode the whole request one phase early. The master still always runs both phases, because it cannot know the target's width until the target is selected. A request that has a non-zero upper address but a command outside memory space is refused. The block raises an error flag and puts nothing on the bus.

Top module: `dacSeqTop`

## Requirements
- R1: After reset, frameOut, busy, parValid, doneValid and errFlag are all low, and adOut and cbeOut are zero.
- R2: An accepted request whose address bits 63:32 are zero produces exactly one cycle with frameOut high. In that cycle adOut[31:0] equals address bits 31:0 and cbeOut[3:0] equals the request command.
- R3: An accepted memory-command request with non-zero address bits 63:32 produces frameOut high for exactly two consecutive cycles.
- R4: In the first phase of a dual cycle, adOut[31:0] carries address bits 31:0 and cbeOut[3:0] carries the dual-address code 4'b1101.
- R5: With BUS64=1, the first phase of a dual cycle drives address bits 63:32 on adOut[63:32] and the request command on cbeOut[7:4]. In every other cycle those upper lanes are zero.
- R6: In the second phase of a dual cycle, adOut[31:0] carries address bits 63:32 and cbeOut[3:0] carries the request command.
- R7: One cycle after every cycle with frameOut high, parValid is high. In that cycle parOut equals the XOR of the previous cycle's adOut[31:0] and cbeOut[3:0], which makes the parity even.
- R8: The memory commands are 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111. A request with any other command and non-zero address bits 63:32 raises errFlag for one cycle, one cycle after acceptance. It gives no frameOut and no busy.
- R9: One cycle after the last address phase, doneValid pulses for one cycle. In that cycle doneAddr, doneCmd and doneDual carry the request's address, its command and whether two phases were used.
- R10: A request is accepted only when reqValid is high and busy is low. Requests presented while busy is high leave the sequence and the outputs unchanged.
- R11: A non-memory command whose address bits 63:32 are zero runs a normal single address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 64 | Request byte address |
| reqCmd | input | 4 | Request bus command |
| busy | output | 1 | Sequence in progress; new requests are not accepted |
| frameOut | output | 1 | Address phase active (frame asserted) |
| adOut | output | ADW (64 by default, 32 when BUS64=0) | Address/data lane contents |
| cbeOut | output | ADW/8 | Command/byte-enable lane contents (command code values) |
| parValid | output | 1 | parOut is meaningful this cycle |
| parOut | output | 1 | Even parity over the previous cycle's low lanes |
| doneValid | output | 1 | Hand-off to data-phase logic |
| doneAddr | output | 64 | Address handed off |
| doneCmd | output | 4 | Command handed off |
| doneDual | output | 1 | Hand-off followed a dual cycle |
| errFlag | output | 1 | Request refused |

## Verification
Each result has its own latency after the accepting edge. The first address phase, or the error flag, appears in the next cycle. The second address phase follows one cycle later. Parity for each phase lags that phase by one cycle. The hand-off pulse arrives one cycle after the last phase: two cycles after acceptance for a single phase and three cycles after for a dual cycle. For each request the driver queues one expected item per cycle in that order. The monitor pops one item per clock, one time unit after the edge, so every output is compared in the exact cycle it is due.

// File: rtl/dacPkg.sv
package dacPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_HAND = 2'd3
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic reject;
    logic phaseOne;
    logic phaseTwo;
    logic handoff;
    logic dual;
  } seqStrobe_t;

  localparam logic [3:0] CMD_DUAL = 4'b1101;

  function automatic logic isMemCmd(input logic [3:0] code);
    case (code)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dacCtrl.sv
module dacCtrl
  import dacPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqCmd,
  input  logic       upperNonZero,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_t state, stateNext;
  logic      dualReg;
  logic      accept;
  logic      legal;

  assign accept = reqValid && (state == ST_IDLE);
  assign legal  = !upperNonZero || isMemCmd(reqCmd);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept && legal) stateNext = ST_PH1;
      ST_PH1:  stateNext = dualReg ? ST_PH2 : ST_HAND;
      ST_PH2:  stateNext = ST_HAND;
      ST_HAND: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dualReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept && legal) dualReg <= upperNonZero;
    end
  end

  always_comb begin
    strobe.capture  = accept && legal;
    strobe.reject   = accept && !legal;
    strobe.phaseOne = (state == ST_PH1);
    strobe.phaseTwo = (state == ST_PH2);
    strobe.handoff  = (state == ST_HAND);
    strobe.dual     = dualReg;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dacDatapath.sv
module dacDatapath
  import dacPkg::*;
#(
  parameter int BUS64 = 1,
  localparam int ADW = (BUS64 != 0) ? 64 : 32,
  localparam int CBW = ADW / 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strobe,
  input  logic [63:0]    reqAddr,
  input  logic [3:0]     reqCmd,
  output logic           frameOut,
  output logic [ADW-1:0] adOut,
  output logic [CBW-1:0] cbeOut,
  output logic           parValid,
  output logic           parOut,
  output logic           doneValid,
  output logic [63:0]    doneAddr,
  output logic [3:0]     doneCmd,
  output logic           doneDual,
  output logic           errFlag
);

  logic [63:0] addrReg;
  logic [3:0]  cmdReg;
  logic [31:0] adLow;
  logic [3:0]  cbeLow;
  logic        parReg;
  logic        parValidReg;
  logic        errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      cmdReg  <= '0;
    end else if (strobe.capture) begin
      addrReg <= reqAddr;
      cmdReg  <= reqCmd;
    end
  end

  always_comb begin
    adLow  = '0;
    cbeLow = '0;
    if (strobe.phaseOne) begin
      adLow  = addrReg[31:0];
      cbeLow = strobe.dual ? CMD_DUAL : cmdReg;
    end else if (strobe.phaseTwo) begin
      adLow  = addrReg[63:32];
      cbeLow = cmdReg;
    end
  end

  generate
    if (BUS64 != 0) begin : g_wide
      logic [31:0] adHigh;
      logic [3:0]  cbeHigh;
      always_comb begin
        adHigh  = '0;
        cbeHigh = '0;
        if (strobe.phaseOne && strobe.dual) begin
          adHigh  = addrReg[63:32];
          cbeHigh = cmdReg;
        end
      end
      assign adOut  = {adHigh, adLow};
      assign cbeOut = {cbeHigh, cbeLow};
    end else begin : g_narrow
      assign adOut  = adLow;
      assign cbeOut = cbeLow;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parReg      <= 1'b0;
      parValidReg <= 1'b0;
      errReg      <= 1'b0;
    end else begin
      parValidReg <= strobe.phaseOne || strobe.phaseTwo;
      parReg      <= ^{adLow, cbeLow};
      errReg      <= strobe.reject;
    end
  end

  assign frameOut  = strobe.phaseOne || strobe.phaseTwo;
  assign parValid  = parValidReg;
  assign parOut    = parReg & parValidReg;
  assign errFlag   = errReg;
  assign doneValid = strobe.handoff;
  assign doneAddr  = strobe.handoff ? addrReg : '0;
  assign doneCmd   = strobe.handoff ? cmdReg : '0;
  assign doneDual  = strobe.handoff & strobe.dual;

endmodule

// File: rtl/dacSeqTop.sv
module dacSeqTop
  import dacPkg::*;
#(
  parameter int BUS64 = 1,
  localparam int ADW = (BUS64 != 0) ? 64 : 32,
  localparam int CBW = ADW / 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [63:0]    reqAddr,
  input  logic [3:0]     reqCmd,
  output logic           busy,
  output logic           frameOut,
  output logic [ADW-1:0] adOut,
  output logic [CBW-1:0] cbeOut,
  output logic           parValid,
  output logic           parOut,
  output logic           doneValid,
  output logic [63:0]    doneAddr,
  output logic [3:0]     doneCmd,
  output logic           doneDual,
  output logic           errFlag
);

  seqStrobe_t strobe;

  dacCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqCmd       (reqCmd),
    .upperNonZero (|reqAddr[63:32]),
    .strobe       (strobe),
    .busy         (busy)
  );

  dacDatapath #(.BUS64(BUS64)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqCmd    (reqCmd),
    .frameOut  (frameOut),
    .adOut     (adOut),
    .cbeOut    (cbeOut),
    .parValid  (parValid),
    .parOut    (parOut),
    .doneValid (doneValid),
    .doneAddr  (doneAddr),
    .doneCmd   (doneCmd),
    .doneDual  (doneDual),
    .errFlag   (errFlag)
  );

endmodule

// File: rtl/dacSeqChecker.sv
module dacSeqChecker
  import dacPkg::*;
#(
  parameter int BUS64 = 1,
  localparam int ADW = (BUS64 != 0) ? 64 : 32,
  localparam int CBW = ADW / 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic [63:0]    reqAddr,
  input logic [3:0]     reqCmd,
  input logic           busy,
  input logic           frameOut,
  input logic [ADW-1:0] adOut,
  input logic [CBW-1:0] cbeOut,
  input logic           parValid,
  input logic           parOut,
  input logic           doneValid,
  input logic           errFlag
);

  p_single_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameOut) && cbeOut[3:0] != CMD_DUAL) |=> !frameOut);

  p_dual_two_phases_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameOut) && cbeOut[3:0] == CMD_DUAL) |=> frameOut);

  p_frame_max_two_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameOut && $past(frameOut)) |=> !frameOut);

  p_second_real_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameOut && $past(frameOut)) |-> cbeOut[3:0] != CMD_DUAL);

  p_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameOut |=> (parValid && parOut == ^$past({adOut[31:0], cbeOut[3:0]})));

  p_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqAddr[63:32] != 32'd0 && !isMemCmd(reqCmd))
      |=> (errFlag && !frameOut && !busy));

  p_handoff_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOut) |-> doneValid);

  p_idle_lanes_r5: assert property (@(posedge clk) disable iff (!rstN)
    !frameOut |-> (adOut == '0 && cbeOut == '0));

endmodule

bind dacSeqTop dacSeqChecker #(.BUS64(BUS64)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqCmd    (reqCmd),
  .busy      (busy),
  .frameOut  (frameOut),
  .adOut     (adOut),
  .cbeOut    (cbeOut),
  .parValid  (parValid),
  .parOut    (parOut),
  .doneValid (doneValid),
  .errFlag   (errFlag)
);

// File: tb/dacSeqTop_bench.sv
`timescale 1ns/1ps
module dacSeqTop_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [3:0]  reqCmd = '0;
  logic        busy, frameOut, parValid, parOut, doneValid, doneDual, errFlag;
  logic [63:0] adOut;
  logic [7:0]  cbeOut;
  logic [63:0] doneAddr;
  logic [3:0]  doneCmd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dacSeqTop u_dacSeqTop (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .busy(busy), .frameOut(frameOut), .adOut(adOut),
    .cbeOut(cbeOut), .parValid(parValid), .parOut(parOut),
    .doneValid(doneValid), .doneAddr(doneAddr), .doneCmd(doneCmd),
    .doneDual(doneDual), .errFlag(errFlag)
  );

  typedef struct {
    logic        frame;
    logic        busy;
    logic [63:0] ad;
    logic [7:0]  cbe;
    logic        pv;
    logic        par;
    logic        dv;
    logic [63:0] da;
    logic [3:0]  dc;
    logic        dd;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic expItem_t blank(input string tag);
    expItem_t it;
    it.frame = 0; it.busy = 0; it.ad = '0; it.cbe = '0; it.pv = 0; it.par = 0;
    it.dv = 0; it.da = '0; it.dc = '0; it.dd = 0; it.err = 0; it.tag = tag;
    return it;
  endfunction

  function automatic logic memCmd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  // Pushes the per-cycle expectation for one request; returns its length.
  function automatic int pushExpected(input logic [63:0] a, input logic [3:0] c, input string tag);
    expItem_t it, prev;
    if (a[63:32] != 0 && !memCmd(c)) begin
      it = blank("R8"); it.err = 1; expQ.push_back(it);
      return 1;
    end
    if (a[63:32] == 0) begin
      it = blank(tag); it.frame = 1; it.busy = 1;
      it.ad = {32'd0, a[31:0]}; it.cbe = {4'd0, c};
      expQ.push_back(it); prev = it;
      it = blank(tag); it.busy = 1; it.pv = 1; it.par = ^{prev.ad[31:0], prev.cbe[3:0]};
      it.dv = 1; it.da = a; it.dc = c; it.dd = 0;
      expQ.push_back(it);
      return 2;
    end
    it = blank(tag); it.frame = 1; it.busy = 1;
    it.ad = {a[63:32], a[31:0]}; it.cbe = {c, 4'b1101};
    expQ.push_back(it); prev = it;
    it = blank(tag); it.frame = 1; it.busy = 1;
    it.ad = {32'd0, a[63:32]}; it.cbe = {4'd0, c};
    it.pv = 1; it.par = ^{prev.ad[31:0], prev.cbe[3:0]};
    expQ.push_back(it); prev = it;
    it = blank(tag); it.busy = 1; it.pv = 1; it.par = ^{prev.ad[31:0], prev.cbe[3:0]};
    it.dv = 1; it.da = a; it.dc = c; it.dd = 1;
    expQ.push_back(it);
    return 3;
  endfunction

  task automatic runReq(input logic [63:0] a, input logic [3:0] c, input string tag, input bit hold);
    int n;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqCmd = c;
    n = pushExpected(a, c, tag);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (hold) begin
        reqAddr = ~a; reqCmd = 4'b0111;   // R10: must be ignored while busy
      end else begin
        reqValid = 0;
      end
    end
    @(negedge clk);
    reqValid = 0;
    expQ.push_back(blank(tag));
  endtask

  // Monitor: one expected item per clock, sampled 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        chk({e.tag, " frame"}, {63'd0, frameOut}, {63'd0, e.frame});
        chk({e.tag, " busy R10"}, {63'd0, busy}, {63'd0, e.busy});
        chk({e.tag, " ad R4 R5 R6"}, adOut, e.ad);
        chk({e.tag, " cbe R4 R5 R6"}, {56'd0, cbeOut}, {56'd0, e.cbe});
        chk("R7 parValid", {63'd0, parValid}, {63'd0, e.pv});
        if (e.pv) chk("R7 parOut", {63'd0, parOut}, {63'd0, e.par});
        chk("R9 doneValid", {63'd0, doneValid}, {63'd0, e.dv});
        if (e.dv) begin
          chk("R9 doneAddr", doneAddr, e.da);
          chk("R9 doneCmd", {60'd0, doneCmd}, {60'd0, e.dc});
          chk("R9 doneDual", {63'd0, doneDual}, {63'd0, e.dd});
        end
        chk("R8 errFlag", {63'd0, errFlag}, {63'd0, e.err});
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 frame", {63'd0, frameOut}, 64'd0);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 parValid", {63'd0, parValid}, 64'd0);
    chk("R1 doneValid", {63'd0, doneValid}, 64'd0);
    chk("R1 errFlag", {63'd0, errFlag}, 64'd0);
    chk("R1 adOut", adOut, 64'd0);
    chk("R1 cbeOut", {56'd0, cbeOut}, 64'd0);

    runReq(64'h0000_0000_1234_5678, 4'b0110, "R2", 0);
    runReq(64'h0000_0001_8000_0004, 4'b0111, "R3", 0);
    runReq(64'h0000_0000_0000_0CF8, 4'b0010, "R11", 0);
    runReq(64'h0000_0002_0000_0010, 4'b0011, "R8", 0);
    runReq(64'h8000_0000_0000_0000, 4'b1010, "R8", 0);
    runReq(64'hABCD_0123_4567_89A0, 4'b1100, "R10", 1);
    runReq(64'h0000_0000_FFFF_FFFC, 4'b1110, "R2", 1);
    runReq(64'h0000_0001_0000_0000, 4'b0110, "R4", 0);
    runReq(64'hFFFF_FFFF_FFFF_FFFF, 4'b1111, "R6", 0);
    runReq(64'h0000_7000_0000_0040, 4'b0111, "R5", 0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule